// File: doc/BRIEF.md
# Debounced Rail Status and Alert Register

This block watches the telemetry of one supply rail and turns it into status flags for a host. On every sample strobe it receives one output-voltage, one output-current and one temperature code. Fault checks act on each raw sample, so a fault is flagged on the very first sample that crosses its limit. Warning checks act on a per-channel block average, and a warning is flagged only after a programmable number of consecutive qualifying averages. The voltage and current channels average 4 samples. The temperature channel averages 16, so its warnings react more slowly and chatter less.

Each flag is sticky. A host reads a domain register to retrieve the flags of that domain, and the read also clears them. A summary word gathers the domains. An active-low alert output calls the host while any flag is pending or any condition is still present. The limits are separate for warning and fault: the undervoltage warning limit is set above the undervoltage fault limit, and the overvoltage warning limit below the overvoltage fault limit.

Top module: `rail_status_alert`

## Requirements
- R1: A fault flag sets at the clock edge that captures the first sample beyond its fault limit. Neither averaging nor debounce applies to it.
- R2: The warning paths compare the floor of the mean of each aligned block of valid samples. The block is 4 samples for voltage and current and 16 samples for temperature.
- R3: A warning flag sets on the averaged result that completes a run of `dbc_len` consecutive qualifying averages. Any non-qualifying average restarts the run. A `dbc_len` of 0 acts as 1.
- R4: Undervoltage qualifies when the value is strictly below its limit. Overvoltage, overcurrent and over-temperature qualify when the value is strictly above their limits. A value equal to a limit never qualifies.
- R5: A flag stays set after its condition has gone, until a read clears it.
- R6: Reading address 1, 2 or 3 returns that domain's flags and clears them. Address 1 is voltage, with bit0 UV warn, bit1 UV fault, bit2 OV warn and bit3 OV fault. Address 2 is current, with bit0 OC warn and bit1 OC fault. Address 3 is temperature, with bit0 OT warn and bit1 OT fault. Reading address 0 clears nothing. A flag that sets in the same cycle as a read that clears it survives that read.
- R7: `rd_valid` and `rd_data` follow `rd_en` by exactly one clock.
- R8: The summary word at address 0 has these bits: bit0 is any voltage flag, bit1 any current flag, bit2 any temperature flag, bit3 any fault flag, bit4 any warning flag and bit7 alert asserted. Bits 6:5 read 0.
- R9: `alert_n` is low while any flag is set, while the last sample still exceeds a fault limit, or while a warning run has reached `dbc_len`. Otherwise it is high.
- R10: A condition that persists across a read sets its flag again on the next qualifying sample or average.
- R11: After reset all flags are clear, `alert_n` is high and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_vld | input | 1 | One pulse per telemetry sample set |
| vout_samp | input | W | Output-voltage code |
| iout_samp | input | W | Output-current code |
| temp_samp | input | W | Temperature code |
| uv_warn_thr | input | W | Undervoltage warning limit |
| uv_fault_thr | input | W | Undervoltage fault limit |
| ov_warn_thr | input | W | Overvoltage warning limit |
| ov_fault_thr | input | W | Overvoltage fault limit |
| oc_warn_thr | input | W | Overcurrent warning limit |
| oc_fault_thr | input | W | Overcurrent fault limit |
| ot_warn_thr | input | W | Over-temperature warning limit |
| ot_fault_thr | input | W | Over-temperature fault limit |
| dbc_len | input | DBC_W | Consecutive averages needed for a warning |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 2 | Register select |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| alert_n | output | 1 | Active-low alert |

## Verification
Embedded assertions check several properties on every cycle. A fault sample sets its flag at once. No flag falls except through a clearing read, and a summary read clears nothing. Read data arrives exactly one cycle after the request. Averaged results never come on back-to-back cycles. A debounce run moves only when an average arrives. A high alert never coexists with a pending flag. Only the bench scenarios can show the rest: the exact debounce length and restart, the rounding of the 16-sample temperature mean, the strict limit comparisons, the re-setting of a persistent condition after a read, and the rule that a set wins over a clear when both fall in the same cycle.

// File: rtl/rsa_pkg.sv
// Shared constants for the rail status block: flag positions, register
// addresses and the flag vector type. Assumes four monitored conditions,
// each owning a warning bit (even) and a fault bit (odd) in that order.
package rsa_pkg;
    localparam int NCOND = 4;               // UV, OV, OC, OT
    localparam int NFLAG = 2 * NCOND;
    localparam int NCHAN = 3;               // voltage, current, temperature

    typedef logic [NFLAG-1:0] flag_vec_t;

    localparam int F_UVW = 0;
    localparam int F_UVF = 1;
    localparam int F_OVW = 2;
    localparam int F_OVF = 3;
    localparam int F_OCW = 4;
    localparam int F_OCF = 5;
    localparam int F_OTW = 6;
    localparam int F_OTF = 7;

    localparam logic [1:0] ADR_SUM  = 2'd0;
    localparam logic [1:0] ADR_VOUT = 2'd1;
    localparam logic [1:0] ADR_IOUT = 2'd2;
    localparam logic [1:0] ADR_TEMP = 2'd3;
endpackage

// File: rtl/rsa_avg.sv
// Block averager: sums 2**LG consecutive valid samples and emits the
// floor of their mean with a one-cycle strobe on the edge after the last
// sample of the block. Assumes LG >= 1.
module rsa_avg #(
    parameter int W  = 12,
    parameter int LG = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_val,
    output logic         avg_vld,
    output logic [W-1:0] avg_val
);
    localparam int AW = W + LG;

    logic [LG-1:0] cnt;
    logic [AW-1:0] acc;
    logic [AW-1:0] sum_c;

    // Running sum including the sample presented this cycle.
    assign sum_c = acc + {{LG{1'b0}}, in_val};

    // Accumulate a block, then publish its mean and restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            acc     <= '0;
            avg_vld <= 1'b0;
            avg_val <= '0;
        end else begin
            avg_vld <= 1'b0;
            if (in_vld) begin
                if (&cnt) begin
                    avg_val <= sum_c[AW-1:LG];
                    avg_vld <= 1'b1;
                    acc     <= '0;
                    cnt     <= '0;
                end else begin
                    acc <= sum_c;
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // A block needs at least two samples, so results never come back to back.
    p_avg_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        avg_vld |=> !avg_vld);
endmodule

// File: rtl/rsa_debounce.sv
// Warning qualifier: counts consecutive qualifying averages and reports a
// hit on the average that completes a run of dbc_len (0 treated as 1).
// BELOW selects "strictly below the limit" instead of "strictly above".
// The run counter saturates at its maximum.
module rsa_debounce #(
    parameter int W     = 12,
    parameter int CW    = 3,
    parameter bit BELOW = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          avg_vld,
    input  logic [W-1:0]  avg_val,
    input  logic [W-1:0]  thr,
    input  logic [CW-1:0] dbc_len,
    output logic          hit,
    output logic          live
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] need;
    logic          qual;

    // Limit comparison in the configured direction.
    assign qual    = BELOW ? (avg_val < thr) : (avg_val > thr);
    // Effective run length and saturating increment.
    assign need    = (dbc_len == '0) ? {{(CW-1){1'b0}}, 1'b1} : dbc_len;
    assign cnt_inc = (&cnt) ? cnt : cnt + 1'b1;
    assign hit     = avg_vld && qual && (cnt_inc >= need);
    assign live    = (cnt >= need);

    // Extend the run on a qualifying average, restart it on any other.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (avg_vld) begin
            cnt <= qual ? cnt_inc : '0;
        end
    end

    p_run_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !avg_vld |=> $stable(cnt));
endmodule

// File: rtl/rail_status_alert.sv
// Rail status register: raw-sample fault checks, averaged and debounced
// warning checks, sticky flags cleared by domain reads, a summary word
// and an active-low alert. Assumes all channels share one sample strobe
// and that warning limits are set inside their fault limits.
module rail_status_alert #(
    parameter int W     = 12,
    parameter int V_LG  = 2,
    parameter int I_LG  = 2,
    parameter int T_LG  = 4,
    parameter int DBC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_vld,
    input  logic [W-1:0]     vout_samp,
    input  logic [W-1:0]     iout_samp,
    input  logic [W-1:0]     temp_samp,
    input  logic [W-1:0]     uv_warn_thr,
    input  logic [W-1:0]     uv_fault_thr,
    input  logic [W-1:0]     ov_warn_thr,
    input  logic [W-1:0]     ov_fault_thr,
    input  logic [W-1:0]     oc_warn_thr,
    input  logic [W-1:0]     oc_fault_thr,
    input  logic [W-1:0]     ot_warn_thr,
    input  logic [W-1:0]     ot_fault_thr,
    input  logic [DBC_W-1:0] dbc_len,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             alert_n
);
    import rsa_pkg::*;

    logic [W-1:0] ch_samp  [NCHAN];
    logic [W-1:0] ch_avg   [NCHAN];
    logic         ch_avg_v [NCHAN];
    logic [W-1:0] warn_thr [NCOND];
    logic [W-1:0] fault_thr[NCOND];

    logic [NCOND-1:0] warn_hit, warn_live, fault_cond, fault_live;
    flag_vec_t        flags, set_v, clr_v;
    logic [7:0]       summary, rd_mux;
    logic             warn_any, fault_any;

    assign ch_samp[0] = vout_samp;
    assign ch_samp[1] = iout_samp;
    assign ch_samp[2] = temp_samp;

    assign warn_thr[0]  = uv_warn_thr;
    assign warn_thr[1]  = ov_warn_thr;
    assign warn_thr[2]  = oc_warn_thr;
    assign warn_thr[3]  = ot_warn_thr;
    assign fault_thr[0] = uv_fault_thr;
    assign fault_thr[1] = ov_fault_thr;
    assign fault_thr[2] = oc_fault_thr;
    assign fault_thr[3] = ot_fault_thr;

    // One averager per channel, depth chosen per channel.
    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        localparam int LGC = (c == 0) ? V_LG : ((c == 1) ? I_LG : T_LG);
        rsa_avg #(.W(W), .LG(LGC)) u_avg (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_vld  (samp_vld),
            .in_val  (ch_samp[c]),
            .avg_vld (ch_avg_v[c]),
            .avg_val (ch_avg[c])
        );
    end

    // Per condition: debounced warning on the average, raw fault compare.
    for (genvar k = 0; k < NCOND; k++) begin : g_cond
        localparam int CH    = (k < 2) ? 0 : k - 1;
        localparam bit BELOW = (k == 0);

        rsa_debounce #(.W(W), .CW(DBC_W), .BELOW(BELOW)) u_dbc (
            .clk     (clk),
            .rst_n   (rst_n),
            .avg_vld (ch_avg_v[CH]),
            .avg_val (ch_avg[CH]),
            .thr     (warn_thr[k]),
            .dbc_len (dbc_len),
            .hit     (warn_hit[k]),
            .live    (warn_live[k])
        );

        assign fault_cond[k] = BELOW ? (ch_samp[CH] < fault_thr[k])
                                     : (ch_samp[CH] > fault_thr[k]);
        assign set_v[2*k]    = warn_hit[k];
        assign set_v[2*k+1]  = samp_vld && fault_cond[k];
    end

    // Bits cleared by the current read, by domain.
    always_comb begin
        clr_v = '0;
        if (rd_en) begin
            case (rd_addr)
                ADR_VOUT: clr_v = 8'h0F;
                ADR_IOUT: clr_v = 8'h30;
                ADR_TEMP: clr_v = 8'hC0;
                default:  clr_v = '0;
            endcase
        end
    end

    // Sticky flags: a set in the same cycle outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_v) | set_v;
    end

    // Remember whether the latest sample still breaks a fault limit.
    always_ff @(posedge clk) begin
        if (!rst_n)        fault_live <= '0;
        else if (samp_vld) fault_live <= fault_cond;
    end

    assign alert_n   = ~(|flags || |fault_live || |warn_live);
    assign warn_any  = flags[F_UVW] | flags[F_OVW] | flags[F_OCW] | flags[F_OTW];
    assign fault_any = flags[F_UVF] | flags[F_OVF] | flags[F_OCF] | flags[F_OTF];
    assign summary   = {~alert_n, 2'b00, warn_any, fault_any,
                        |flags[F_OTF:F_OTW], |flags[F_OCF:F_OCW], |flags[F_OVF:F_UVW]};

    // Read data selection.
    always_comb begin
        case (rd_addr)
            ADR_VOUT: rd_mux = {4'b0000, flags[F_OVF:F_UVW]};
            ADR_IOUT: rd_mux = {6'b000000, flags[F_OCF:F_OCW]};
            ADR_TEMP: rd_mux = {6'b000000, flags[F_OTF:F_OTW]};
            default:  rd_mux = summary;
        endcase
    end

    // Registered read port, one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_mux;
        end
    end

    p_fault_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        samp_vld && (iout_samp > oc_fault_thr) |=> flags[F_OCF]);
    p_sticky_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ((flags & $past(flags)) == $past(flags)));
    p_sum_noclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (rd_addr == ADR_SUM) |=> ((flags & $past(flags)) == $past(flags)));
    p_rd_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    p_rd_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    p_alert_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alert_n |-> (flags == '0));
endmodule

// File: tb/rail_status_alert_test.sv
module rail_status_alert_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        samp_vld = 1'b0;
    logic [11:0] vout_s = 12'd500, iout_s = 12'd100, temp_s = 12'd300;
    logic [2:0]  dbc = 3'd3;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = 2'd0;
    logic        rd_valid, alert_n;
    logic [7:0]  rd_data;

    int checks = 0, failures = 0, nsamp = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    rail_status_alert uut (
        .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld),
        .vout_samp(vout_s), .iout_samp(iout_s), .temp_samp(temp_s),
        .uv_warn_thr(12'd200), .uv_fault_thr(12'd100),
        .ov_warn_thr(12'd800), .ov_fault_thr(12'd900),
        .oc_warn_thr(12'd500), .oc_fault_thr(12'd700),
        .ot_warn_thr(12'd600), .ot_fault_thr(12'd800),
        .dbc_len(dbc), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .alert_n(alert_n)
    );

    task automatic check_eq(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic samp(input logic [11:0] v, input logic [11:0] i, input logic [11:0] t);
        @(negedge clk);
        samp_vld = 1'b1; vout_s = v; iout_s = i; temp_s = t;
        @(negedge clk);
        samp_vld = 1'b0;
        nsamp++;
    endtask

    task automatic nom(input int n);
        repeat (n) samp(12'd500, 12'd100, 12'd300);
    endtask

    task automatic pad16();
        while (nsamp % 16 != 0) nom(1);
    endtask

    // Driver: issue a read and push its expected result to the scoreboard.
    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Monitor: pop and compare whenever the design returns read data.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R7 unexpected rd_valid actual=1 expected=0");
            end else begin
                check_eq(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog R7 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check_eq("R11 alert_n after reset", {7'b0, alert_n}, 8'h01);
        check_eq("R11 rd_valid after reset", {7'b0, rd_valid}, 8'h00);
        rd(2'd0, 8'h00, "R11 summary after reset");
        rd(2'd1, 8'h00, "R11 vout flags after reset");
        rd(2'd2, 8'h00, "R11 iout flags after reset");
        rd(2'd3, 8'h00, "R11 temp flags after reset");

        // R1: one overcurrent sample sets the fault at once
        samp(12'd500, 12'd701, 12'd300); nom(3); idle(2);
        check_eq("R9 alert low with pending fault", {7'b0, alert_n}, 8'h00);
        rd(2'd2, 8'h02, "R1 oc fault on first sample");
        check_eq("R9 alert released after read", {7'b0, alert_n}, 8'h01);
        rd(2'd2, 8'h00, "R6 iout flags cleared by read");

        // R4: values equal to a limit do not qualify
        samp(12'd500, 12'd700, 12'd300); nom(3);
        samp(12'd900, 12'd100, 12'd300); nom(3);
        samp(12'd100, 12'd100, 12'd300); nom(3); idle(2);
        rd(2'd1, 8'h00, "R4 equal to uv/ov fault limit");
        rd(2'd2, 8'h00, "R4 equal to oc fault limit");

        // R8 and R6: summary read does not clear, domain read does
        samp(12'd99, 12'd100, 12'd300); nom(3); idle(2);
        rd(2'd0, 8'h89, "R8 summary with uv fault");
        rd(2'd1, 8'h02, "R6 uv fault kept after summary read");
        check_eq("R9 alert high after clear", {7'b0, alert_n}, 8'h01);
        nom(3); samp(12'd99, 12'd100, 12'd300); idle(2);
        rd(2'd1, 8'h02, "R1 uv fault again");
        check_eq("R9 live fault holds alert", {7'b0, alert_n}, 8'h00);
        nom(4); idle(2);
        check_eq("R9 alert high once condition gone", {7'b0, alert_n}, 8'h01);

        // R3 and R10: overvoltage warning, run of 3 averages
        repeat (8) samp(12'd850, 12'd100, 12'd300); idle(2);
        check_eq("R3 alert high after two averages", {7'b0, alert_n}, 8'h01);
        rd(2'd1, 8'h00, "R3 no warn after two averages");
        repeat (4) samp(12'd850, 12'd100, 12'd300); idle(2);
        check_eq("R9 alert low on warning", {7'b0, alert_n}, 8'h00);
        rd(2'd1, 8'h04, "R3 ov warn on third average");
        repeat (4) samp(12'd850, 12'd100, 12'd300); idle(2);
        rd(2'd1, 8'h04, "R10 persistent warn sets again");
        nom(4); idle(2);
        check_eq("R9 alert high after warn run ends", {7'b0, alert_n}, 8'h01);
        rd(2'd1, 8'h00, "R6 vout flags clear");

        // R3: a non-qualifying average restarts the run
        repeat (8) samp(12'd850, 12'd100, 12'd300);
        nom(4);
        repeat (8) samp(12'd850, 12'd100, 12'd300); idle(2);
        rd(2'd1, 8'h00, "R3 run restarted by nominal average");
        repeat (4) samp(12'd850, 12'd100, 12'd300); idle(2);
        rd(2'd1, 8'h04, "R3 warn after three consecutive");
        nom(4);

        // R3 with dbc_len 0, R5 flag held after condition ends
        dbc = 3'd0;
        repeat (4) samp(12'd500, 12'd550, 12'd300);
        nom(4); idle(2);
        check_eq("R5 alert low on held flag", {7'b0, alert_n}, 8'h00);
        rd(2'd2, 8'h01, "R3 dbc 0 acts as 1, R5 held oc warn");

        // R2: 16-sample temperature mean, floor rounding
        dbc = 3'd1;
        pad16();
        repeat (15) samp(12'd500, 12'd100, 12'd600);
        samp(12'd500, 12'd100, 12'd615); idle(2);
        rd(2'd3, 8'h00, "R2 temp mean floors to 600");
        repeat (15) samp(12'd500, 12'd100, 12'd600);
        samp(12'd500, 12'd100, 12'd616); idle(2);
        rd(2'd3, 8'h01, "R2 temp mean 601 warns");
        nom(16);
        dbc = 3'd3;

        // R8: temperature fault in the summary word
        samp(12'd500, 12'd100, 12'd801); nom(3); idle(2);
        rd(2'd0, 8'h8C, "R8 summary with ot fault");
        rd(2'd3, 8'h02, "R1 ot fault");
        rd(2'd0, 8'h00, "R8 summary empty");

        // R6: a set in the same cycle as a clearing read survives
        @(negedge clk);
        samp_vld = 1'b1; iout_s = 12'd701; vout_s = 12'd500; temp_s = 12'd300;
        rd_en = 1'b1; rd_addr = 2'd2;
        exp_q.push_back(8'h00); tag_q.push_back("R6 read returns pre-set value");
        @(negedge clk);
        samp_vld = 1'b0; rd_en = 1'b0; nsamp++;
        nom(3); idle(2);
        rd(2'd2, 8'h02, "R6 set wins over clear");

        idle(4);
        if (exp_q.size() != 0) begin
            checks++; failures++;
            $display("FAIL R7 reads unanswered actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule